// File: doc/BRIEF.md
# I2C Target with Byte-Boundary Clock Stretching

This block is the bus-facing half of an I2C target. It uses 7-bit addressing and talks to a local host through a single-entry send buffer and a single-entry capture buffer. Each buffer has a full flag. SCL and SDA arrive through a short synchronizer chain. The block drives both lines as open-drain pull-down enables. A START moves the engine to address reception. A STOP returns it to idle. A matching address is acknowledged, and the direction bit then selects between capturing bytes from the controller and sending bytes to it.

The host needs time to fetch a captured byte or to supply the next one. To give it that time, the block can hold SCL low after the acknowledge clock that closes each byte. The decision is taken on the falling SCL edge that ends that ninth clock, from the buffer state at that moment. When sending, the block always holds the clock if nothing is queued. When capturing, it holds the clock only if the stretch enable is set and the previous byte has not been collected. A release bit shows whether the clock is free. The host sets this bit to let the bus run again. With the stretch enable set, the host may also clear it to hold the clock of its own accord. Such a hold only begins once SCL is seen low, so a high phase is never cut short.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset both pull-down enables are 0, the send and capture full flags and the overflow flag are 0, and the release bit is 1.
- R2: The first byte after a START is taken as address (bits 7..1) and direction (bit 0, 1 = controller reads). A match with `own_addr` is acknowledged by pulling SDA low in the ninth clock. A mismatch is answered with SDA released, and the block ignores the bus until the next START.
- R3: In the write direction, bits are sampled MSB first on rising SCL. A completed byte goes to `rx_data`, sets `rx_full` and is acknowledged. A one-cycle `rx_rd` pulse clears `rx_full`.
- R4: In the write direction, with `stretch_en` = 1 and `rx_full` = 1 at the ninth falling edge, the release bit clears and SCL is pulled low. The pull stays until the host sets the release bit.
- R5: No capture-side stretch occurs when `stretch_en` = 0, or when the host has collected the byte before the ninth falling edge.
- R6: A byte that completes while `rx_full` = 1 is answered with SDA released. It sets `overflow` and leaves `rx_data` unchanged. `rx_rd` also clears `overflow`.
- R7: A matching read address moves the queued send byte into the shifter, clears `tx_full`, and drives it MSB first, with each bit changed after a falling SCL.
- R8: In the read direction, if the controller acknowledges and `tx_full` = 0 at the ninth falling edge, SCL is held low whatever `stretch_en` is. A byte queued during the hold is picked up at once. A byte queued before that edge prevents the hold and is sent next.
- R9: A controller NACK after a sent byte ends sending. SDA stays released and no hold occurs.
- R10: Writing 1 to the release bit takes effect at any time, whatever the buffer flags show, and SCL is then let go.
- R11: With `stretch_en` = 1, writing 0 to the release bit clears it. SCL is pulled low only while SCL is sampled low, either at once if it is already low or after it next falls.
- R12: With `stretch_en` = 0, writing 0 to the release bit has no effect.
- R13: A START or STOP at any point resets the bit position, releases SDA and sets the release bit.
- R14: The SDA pull-down is asserted only after SCL has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | DATA_W-1 | Address this target answers to |
| stretch_en | input | 1 | Enables capture-side and host-requested clock holds |
| tx_wr | input | 1 | One-cycle pulse queueing `tx_data` for sending |
| tx_data | input | DATA_W | Byte to send |
| tx_full | output | 1 | Send buffer holds a byte |
| rx_rd | input | 1 | One-cycle pulse collecting the captured byte |
| rx_data | output | DATA_W | Last captured byte |
| rx_full | output | 1 | Capture buffer holds an uncollected byte |
| overflow | output | 1 | A byte arrived while the capture buffer was full |
| rel_wr | input | 1 | Host write strobe for the release bit |
| rel_wdata | input | 1 | Value written to the release bit |
| rel | output | 1 | Release bit; 0 means the block holds or will hold SCL |

## Verification
The bench sweeps many non-matching addresses and a spread of data patterns in both directions. It goes after the moment of the ninth-edge decision. A byte collected or queued just before that edge must not cause a hold; a design that sampled the flags at the eighth edge would stall the bus there. A design that made send-side holds depend on the enable would push stale 1s onto the wire. A host hold requested while SCL is high is checked to wait for the low phase, since pulling early would cut a high period short. A STOP or a repeated START in the middle of a byte is checked to leave no stale bit count behind, which would otherwise shift the next address by a few bits.

// File: rtl/its_pkg.sv
`timescale 1ns/100ps
package its_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/its_sync.sv
`timescale 1ns/100ps
// Per-bit synchronizer chain; lines idle high, so reset loads ones.
module its_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-2:0], d[i]};
    end
    assign q[i] = pipe[STAGES-1];
  end
endmodule

// File: rtl/its_events.sv
`timescale 1ns/100ps
// Edge and bus-condition detection on synchronized lines.
module its_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/its_release.sv
`timescale 1ns/100ps
// Release bit and SCL pull-down: a hold only starts while SCL is sampled low.
module its_release (
  input  logic clk,
  input  logic rst,
  input  logic stretch_en,
  input  logic wr,
  input  logic wdata,
  input  logic auto_clr,
  input  logic bus_evt,
  input  logic scl_s,
  output logic rel,
  output logic scl_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rel    <= 1'b1;
      scl_oe <= 1'b0;
    end else begin
      if (bus_evt)                       rel <= 1'b1;
      else if (wr && wdata)              rel <= 1'b1;
      else if (auto_clr)                 rel <= 1'b0;
      else if (wr && !wdata && stretch_en) rel <= 1'b0;
      scl_oe <= !rel && !scl_s;
    end
  end
endmodule

// File: rtl/i2c_target_stretch.sv
`timescale 1ns/100ps
module i2c_target_stretch
  import its_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              stretch_en,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overflow,
  input  logic              rel_wr,
  input  logic              rel_wdata,
  output logic              rel
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, bus_start, bus_stop, bus_evt;
  logic auto_clr, tx_enter, tx_late, byte_done;

  bus_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx_buf;
  logic              rw, mst_ack, tx_loaded;

  its_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign {scl_s, sda_s} = sync_q;

  its_events u_events (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );
  assign bus_evt = bus_start | bus_stop;

  its_release u_release (
    .clk(clk), .rst(rst), .stretch_en(stretch_en),
    .wr(rel_wr), .wdata(rel_wdata), .auto_clr(auto_clr),
    .bus_evt(bus_evt), .scl_s(scl_s), .rel(rel), .scl_oe(scl_oe)
  );

  assign byte_done = (cnt == CNT_W'(DATA_W));
  assign tx_enter  = scl_fall && ((state == ST_ADDR_ACK && rw) ||
                                  (state == ST_TX_ACK && mst_ack));
  assign tx_late   = (state == ST_TX) && !tx_loaded && (cnt == '0) &&
                     tx_full && !scl_s;

  // Ninth falling edge: hold decision from buffer state at that edge.
  always_comb begin
    auto_clr = 1'b0;
    if (scl_fall) begin
      case (state)
        ST_ADDR_ACK: auto_clr = rw ? !tx_full : (stretch_en && rx_full);
        ST_TX_ACK:   auto_clr = mst_ack && !tx_full;
        ST_RX_ACK:   auto_clr = stretch_en && rx_full;
        default:     auto_clr = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '1;
      tx_buf    <= '0;
      rx_data   <= '0;
      rw        <= 1'b0;
      mst_ack   <= 1'b0;
      tx_loaded <= 1'b0;
      sda_oe    <= 1'b0;
      tx_full   <= 1'b0;
      rx_full   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (bus_start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              cnt <= '0;
              if (shreg[DATA_W-1:1] == own_addr) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= rw ? ST_TX : ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_done) begin
              cnt   <= '0;
              state <= ST_RX_ACK;
              if (rx_full) begin
                overflow <= 1'b1;
              end else begin
                rx_data <= shreg;
                rx_full <= 1'b1;
                sda_oe  <= 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= shreg << 1;
                sda_oe <= !shreg[DATA_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise)      mst_ack <= !sda_s;
            else if (scl_fall) state   <= mst_ack ? ST_TX : ST_SKIP;
          end
          default: ;
        endcase

        if (tx_enter) begin
          cnt <= '0;
          if (tx_full) begin
            shreg     <= tx_buf;
            tx_full   <= 1'b0;
            sda_oe    <= !tx_buf[DATA_W-1];
            tx_loaded <= 1'b1;
          end else begin
            shreg     <= '1;
            sda_oe    <= 1'b0;
            tx_loaded <= 1'b0;
          end
        end else if (tx_late) begin
          shreg     <= tx_buf;
          tx_full   <= 1'b0;
          sda_oe    <= !tx_buf[DATA_W-1];
          tx_loaded <= 1'b1;
        end
      end

      if (tx_wr) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end
      if (rx_rd) begin
        rx_full  <= 1'b0;
        overflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/its_checker.sv
`timescale 1ns/100ps
module its_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              scl_oe,
  input logic              rel,
  input logic              rx_full,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              overflow,
  input logic              bus_evt
);
  assert_sda_pull_in_low_R14: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  assert_scl_hold_in_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !$past(scl_s));

  assert_rx_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd) |=> $stable(rx_data));

  assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(rx_full));

  assert_event_release_R13: assert property (@(posedge clk) disable iff (rst)
    bus_evt |=> (rel && !sda_oe));
endmodule

bind i2c_target_stretch its_checker #(.DATA_W(DATA_W)) u_its_checker (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .rel(rel), .rx_full(rx_full), .rx_rd(rx_rd), .rx_data(rx_data),
  .overflow(overflow), .bus_evt(bus_evt)
);

// File: tb/test_i2c_target_stretch.sv
`timescale 1ns/100ps
module test_i2c_target_stretch;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic stretch_en = 1'b0, tx_wr = 1'b0, rel_wr = 1'b0, rel_wdata = 1'b0;
  logic rd_req = 1'b0, auto_rd = 1'b0, auto_pulse = 1'b0;
  logic [7:0] tx_data = 8'h00, last_rd = 8'h00;
  logic scl_oe, sda_oe, tx_full, rx_full, overflow, rel;
  logic [7:0] rx_data;
  wire scl_bus = !(m_scl_low || scl_oe);
  wire sda_bus = !(m_sda_low || sda_oe);
  wire rx_rd   = rd_req | auto_pulse;

  int n_chk = 0, n_err = 0, viol = 0;
  bit done = 1'b0;

  i2c_target_stretch i_i2c_target_stretch (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .stretch_en(stretch_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .overflow(overflow),
    .rel_wr(rel_wr), .rel_wdata(rel_wdata), .rel(rel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Host collects any captured byte at once while auto_rd is set.
  initial forever begin
    @(negedge clk);
    if (auto_rd && rx_full && !auto_pulse) begin
      last_rd    = rx_data;
      auto_pulse = 1'b1;
    end else begin
      auto_pulse = 1'b0;
    end
  end

  // R14 monitor: SDA pull must not rise across a sampled-high SCL.
  initial begin
    logic p_sda = 1'b0, p_scl = 1'b1;
    forever begin
      @(negedge clk);
      if (sda_oe && !p_sda && p_scl && scl_bus) viol++;
      p_sda = sda_oe;
      p_scl = scl_bus;
    end
  end

  task automatic wait_q;
    repeat (Q) @(negedge clk);
  endtask
  task automatic wait_scl_high;
    while (!scl_bus) @(negedge clk);
  endtask
  task automatic m_start;
    m_sda_low = 1'b0; wait_q;
    m_scl_low = 1'b0; wait_scl_high; wait_q;
    m_sda_low = 1'b1; wait_q;
    m_scl_low = 1'b1; wait_q;
  endtask
  task automatic m_stop;
    m_sda_low = 1'b1; wait_q;
    m_scl_low = 1'b0; wait_scl_high; wait_q;
    m_sda_low = 1'b0; wait_q;
  endtask
  task automatic m_bit_w(input logic b);
    m_sda_low = !b; wait_q;
    m_scl_low = 1'b0; wait_scl_high; wait_q; wait_q;
    m_scl_low = 1'b1; wait_q;
  endtask
  task automatic m_bit_r(output logic b);
    m_sda_low = 1'b0; wait_q;
    m_scl_low = 1'b0; wait_scl_high; wait_q;
    b = sda_bus; wait_q;
    m_scl_low = 1'b1; wait_q;
  endtask
  task automatic m_write_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    m_bit_r(b);
    ack = !b;
  endtask
  task automatic m_read_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_r(b);
      v[i] = b;
    end
    m_bit_w(!ack);
  endtask
  task automatic host_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask
  task automatic host_rel(input logic v);
    @(negedge clk); rel_wdata = v; rel_wr = 1'b1;
    @(negedge clk); rel_wr = 1'b0;
  endtask
  task automatic host_read;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] got, v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 pulls", {scl_oe, sda_oe}, 0);
    chk(!tx_full && !rx_full && !overflow, "R1 flags", {tx_full, rx_full, overflow}, 0);
    chk(rel == 1'b1, "R1 rel", rel, 1);

    // R12: clearing release with stretch disabled is ignored
    host_rel(1'b0); repeat (8) @(negedge clk);
    chk(rel && !scl_oe, "R12 ignored clear", {rel, scl_oe}, 2);

    // R2: address sweep, mismatches are NACKed and ignored
    for (int a = 0; a < 128; a += 5) begin
      if (a[6:0] != OWN) begin
        m_start;
        m_write_byte({a[6:0], 1'b0}, ack);
        chk(!ack, "R2 mismatch nack", ack, 0);
        m_write_byte(8'h99, ack);
        chk(!ack, "R2 ignored data", ack, 0);
        m_stop;
      end
    end
    chk(!rx_full, "R2 nothing captured", rx_full, 0);

    // R3/R5: write sweep, host collects before ninth edge, no hold
    stretch_en = 1'b1; auto_rd = 1'b1;
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    chk(ack, "R2 match ack", ack, 1);
    for (int k = 0; k < 16; k++) begin
      v = 8'((k * 37 + 5) & 255);
      m_write_byte(v, ack);
      chk(ack && last_rd == v, "R3 byte captured", last_rd, v);
      chk(!scl_oe && rel, "R5 read early no hold", scl_oe, 0);
    end
    m_stop;
    auto_rd = 1'b0; repeat (4) @(negedge clk);

    // R4/R10: capture-side hold when enabled and byte not collected
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    m_write_byte(8'h5A, ack);
    chk(ack && rx_full, "R3 full after byte", rx_full, 1);
    chk(scl_oe && !rel, "R4 hold", {scl_oe, rel}, 2);
    repeat (60) @(negedge clk);
    chk(scl_oe, "R4 hold kept", scl_oe, 1);
    chk(rx_data == 8'h5A, "R3 data", rx_data, 8'h5A);
    host_read; repeat (3) @(negedge clk);
    chk(!rx_full, "R3 cleared by read", rx_full, 0);
    chk(scl_oe, "R4 read alone keeps hold", scl_oe, 1);
    host_rel(1'b1); repeat (3) @(negedge clk);
    chk(!scl_oe && rel, "R10 release", scl_oe, 0);
    m_stop;

    // R5/R6: stretch disabled, overflow NACK keeps data
    stretch_en = 1'b0;
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    m_write_byte(8'hC3, ack);
    chk(ack && !scl_oe, "R5 disabled no hold", scl_oe, 0);
    m_write_byte(8'h3C, ack);
    chk(!ack, "R6 overflow nack", ack, 0);
    chk(overflow && rx_data == 8'hC3, "R6 data kept", rx_data, 8'hC3);
    m_stop;
    host_read; repeat (3) @(negedge clk);
    chk(!overflow && !rx_full, "R6 read clears", {overflow, rx_full}, 0);

    // R7/R8/R9/R10: read direction with stretch disabled
    host_tx(8'hA7);
    m_start;
    m_write_byte({OWN, 1'b1}, ack);
    chk(ack && !tx_full, "R7 load on address", tx_full, 0);
    m_read_byte(got, 1'b1);
    chk(got == 8'hA7, "R7 sent byte", got, 8'hA7);
    for (int k = 0; k < 6; k++) begin
      v = 8'((k * 83 + 17) & 255);
      chk(scl_oe && !rel, "R8 send hold", {scl_oe, rel}, 2);
      host_tx(v); repeat (4) @(negedge clk);
      chk(!tx_full, "R8 late pickup", tx_full, 0);
      host_rel(1'b1);
      m_read_byte(got, 1'b1);
      chk(got == v, "R8 byte after hold", got, v);
    end
    host_tx(8'h4E); repeat (4) @(negedge clk);
    host_tx(8'hE1);
    host_rel(1'b1); repeat (3) @(negedge clk);
    chk(!scl_oe, "R10 release send", scl_oe, 0);
    m_read_byte(got, 1'b1);
    chk(got == 8'h4E, "R8 queued byte", got, 8'h4E);
    chk(!scl_oe && rel, "R8 queued no hold", scl_oe, 0);
    m_read_byte(got, 1'b0);
    chk(got == 8'hE1, "R8 second queued", got, 8'hE1);
    chk(!scl_oe && !sda_oe, "R9 nack ends", {scl_oe, sda_oe}, 0);
    m_stop;

    // R11: host-requested hold waits for SCL low
    stretch_en = 1'b1;
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    m_sda_low = 1'b0; wait_q;
    m_scl_low = 1'b0; wait_scl_high; wait_q;
    host_rel(1'b0); repeat (10) @(negedge clk);
    chk(!rel && !scl_oe, "R11 no pull while high", {rel, scl_oe}, 0);
    m_scl_low = 1'b1; repeat (10) @(negedge clk);
    chk(scl_oe, "R11 pull after fall", scl_oe, 1);
    host_rel(1'b1); repeat (5) @(negedge clk);
    chk(!scl_oe, "R10 release after sw hold", scl_oe, 0);
    host_rel(1'b0); repeat (5) @(negedge clk);
    chk(scl_oe, "R11 immediate pull", scl_oe, 1);
    host_rel(1'b1); repeat (5) @(negedge clk);
    for (int i = 6; i >= 0; i--) m_bit_w(i[0] ? 1'b0 : 1'b1);
    m_bit_r(ack);
    chk(rx_data == 8'hD5 && !ack, "R3 byte across sw hold", rx_data, 8'hD5);
    host_read;
    host_rel(1'b1); repeat (3) @(negedge clk);
    m_stop;

    // R13: STOP and repeated START mid-byte
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1);
    m_stop; repeat (4) @(negedge clk);
    chk(!rx_full && !sda_oe && rel, "R13 stop mid byte", {rx_full, sda_oe, rel}, 1);
    m_start;
    m_write_byte({OWN, 1'b0}, ack);
    chk(ack, "R13 fresh address", ack, 1);
    m_write_byte(8'h3C, ack);
    chk(rx_data == 8'h3C, "R13 clean count", rx_data, 8'h3C);
    host_read; host_rel(1'b1);
    m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1); m_bit_w(1'b1);
    host_tx(8'h81);
    m_start;
    m_write_byte({OWN, 1'b1}, ack);
    m_read_byte(got, 1'b0);
    chk(ack && got == 8'h81, "R13 repeated start", got, 8'h81);
    chk(!rx_full, "R13 partial dropped", rx_full, 0);
    m_stop;
    host_rel(1'b0); repeat (6) @(negedge clk);
    chk(!rel, "R11 clear idle", rel, 0);
    m_start;
    chk(rel, "R13 start sets release", rel, 1);
    m_stop;

    chk(viol == 0, "R14 sda change in low", viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule